// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block sits on the memory side of a single-data-rate SDRAM interface and turns WRITE commands into per-word writes for a storage array. It samples the registered command strobes, the bank select and the address on every rising clock edge. When a WRITE is decoded, the data word on the bus at that same edge is taken as the first word of a burst. Every following edge takes one more word until the burst length is reached. A full-page burst instead runs until another WRITE arrives.

Each captured word appears one cycle later on a registered write port, together with its bank and column. The column steps sequentially and wraps inside the aligned block of the burst length. A data mask can drop the strobe for a single word. A new WRITE can arrive on any cycle; it cuts off the running burst and starts a new one, to the same bank or a different one. When address bit 10 is high on a WRITE, a precharge request for that bank is raised with the final word of the burst. That request is dropped if a later WRITE truncates the burst.

Top module: `sdr_wr_engine`

## Requirements
- R1: A WRITE is decoded only for chip select low, row strobe high, column strobe low and write enable low. Any other combination, including the read pattern (0,1,0,1), chip select high, and all strobes low, starts no burst and produces no strobe.
- R2: On the edge that decodes a WRITE, the data bus is captured with no latency. The cycle after that edge shows wr_en_o high, wr_bank_o equal to ba_i, wr_col_o equal to addr_i[7:0], and wr_data_o equal to the sampled dq_i.
- R3: Each following edge of a burst captures one more word. The column advances by one and wraps inside the aligned block of the burst length. blen_i encodes the length as 0=1, 1=2, 2=4, 3=8 and 7=full page (256). Codes 4 to 6 act as length 1.
- R4: Once a fixed-length burst has delivered its last word, data on the bus is ignored and wr_en_o stays low until the next WRITE.
- R5: A full-page burst never ends on its own. Its column increments every cycle and wraps from 255 to 0.
- R6: A WRITE is accepted on any cycle, including during a burst. It truncates the running burst, and the data presented with it belongs to the new burst in the bank it names.
- R7: dqm_i high in a data cycle forces wr_en_o low for that word, but the column still advances.
- R8: A WRITE with addr_i[10] high raises pre_o for one cycle, with pre_bank_o set to the burst's bank. This happens in the same output cycle as the burst's last word.
- R9: If a later WRITE truncates a burst that had auto precharge requested, that precharge is never issued.
- R10: While rst_ni is low, wr_en_o, pre_o and all other outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address; bits 7:0 start column, bit 10 auto precharge |
| dq_i | input | 16 | Write data bus |
| dqm_i | input | 1 | Data mask, high drops the word's strobe |
| blen_i | input | 3 | Static burst length code |
| wr_en_o | output | 1 | Write strobe for the array |
| wr_bank_o | output | 2 | Bank of the written word |
| wr_col_o | output | 8 | Column of the written word |
| wr_data_o | output | 16 | Data of the written word |
| pre_o | output | 1 | Precharge request, one cycle |
| pre_bank_o | output | 2 | Bank to precharge |

## Verification
The embedded properties assume that blen_i is held constant while a burst is in flight. The full-page column check and the burst-length bound both read the code live or from a latch taken at the WRITE. They also assume that the command strobes and buses are settled at each rising edge. The bench changes blen_i only between bursts, in cycles with no burst in progress. It drives every input on the falling edge, so each value is stable across the sampling edge. Besides WRITE, the stimulus presents only command patterns that must be ignored. No other command type is ever expected to end a burst.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } blen_e;

  // offset mask within an aligned burst block; full page masks every column bit
  function automatic logic [15:0] blen_mask(input logic [2:0] code);
    case (code)
      BL_2:    return 16'h0001;
      BL_4:    return 16'h0003;
      BL_8:    return 16'h0007;
      BL_PAGE: return 16'hffff;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/sdr_wr_cmd_dec.sv
module sdr_wr_cmd_dec (
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic wr_o
);
  assign wr_o = !cs_ni && ras_ni && !cas_ni && !we_ni;
endmodule

// File: rtl/sdr_wr_burst.sv
module sdr_wr_burst #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic             beat_o,
  output logic             last_o,
  output logic             act_o,
  output logic [COL_W-1:0] col_o
);
  logic             act_q, full_q;
  logic [COL_W-1:0] col_q, cnt_q, mask_q;
  logic [COL_W-1:0] col_inc, cnt_nxt;

  assign col_inc = col_q + COL_W'(1);
  assign act_o   = act_q;

  always_comb begin
    beat_o  = 1'b0;
    last_o  = 1'b0;
    col_o   = col_q;
    cnt_nxt = cnt_q;
    if (wr_cmd_i) begin
      beat_o  = 1'b1;
      col_o   = start_col_i;
      cnt_nxt = '0;
      last_o  = !full_i && (mask_i == '0);
    end else if (act_q) begin
      beat_o  = 1'b1;
      col_o   = (col_q & ~mask_q) | (col_inc & mask_q);
      cnt_nxt = cnt_q + COL_W'(1);
      last_o  = !full_q && (cnt_nxt == mask_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      col_q  <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (beat_o) begin
        col_q <= col_o;
        cnt_q <= cnt_nxt;
        act_q <= !last_o;
      end
      if (wr_cmd_i) begin
        mask_q <= mask_i;
        full_q <= full_i;
      end
    end
  end

  // R4
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !full_q) |-> (cnt_q < mask_q));

  // R3
  block_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !wr_cmd_i) |-> ((col_o & ~mask_q) == (col_q & ~mask_q)));

endmodule

// File: rtl/sdr_wr_pre.sv
module sdr_wr_pre #(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              ap_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              last_i,
  output logic              pre_o,
  output logic [BANK_W-1:0] pre_bank_o
);
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;

  // a new WRITE overwrites the pending request, cancelling a truncated one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_q       <= 1'b0;
      bank_q     <= '0;
      pre_o      <= 1'b0;
      pre_bank_o <= '0;
    end else begin
      if (wr_cmd_i) begin
        ap_q   <= ap_i;
        bank_q <= bank_i;
      end
      pre_o      <= last_i && (wr_cmd_i ? ap_i : ap_q);
      pre_bank_o <= wr_cmd_i ? bank_i : bank_q;
    end
  end

  // R9
  cancel_ap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd_i && !ap_i) |=> !pre_o);

endmodule

// File: rtl/sdr_wr_engine.sv
module sdr_wr_engine
  import sdr_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic              dqm_i,
  input  logic [2:0]        blen_i,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pre_o,
  output logic [BANK_W-1:0] pre_bank_o
);
  logic              is_wr, beat, last, burst_act, full_sel;
  logic [15:0]       mask_w;
  logic [COL_W-1:0]  mask_sel, col;
  logic [BANK_W-1:0] cur_bank_q;
  logic              unused_addr;

  assign mask_w      = blen_mask(blen_i);
  assign mask_sel    = mask_w[COL_W-1:0];
  assign full_sel    = (blen_i == BL_PAGE);
  assign unused_addr = ^addr_i;

  sdr_wr_cmd_dec u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .wr_o  (is_wr)
  );

  sdr_wr_burst #(.COL_W(COL_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (is_wr),
    .start_col_i(addr_i[COL_W-1:0]),
    .mask_i     (mask_sel),
    .full_i     (full_sel),
    .beat_o     (beat),
    .last_o     (last),
    .act_o      (burst_act),
    .col_o      (col)
  );

  sdr_wr_pre #(.BANK_W(BANK_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cmd_i  (is_wr),
    .ap_i      (addr_i[AP_BIT]),
    .bank_i    (ba_i),
    .last_i    (last),
    .pre_o     (pre_o),
    .pre_bank_o(pre_bank_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_bank_q <= '0;
      wr_en_o    <= 1'b0;
      wr_bank_o  <= '0;
      wr_col_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      if (is_wr) cur_bank_q <= ba_i;
      wr_en_o   <= beat && !dqm_i;
      wr_bank_o <= is_wr ? ba_i : cur_bank_q;
      wr_col_o  <= col;
      wr_data_o <= dq_i;
    end
  end

  // R2
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> (wr_col_o == $past(addr_i[COL_W-1:0])) && (wr_bank_o == $past(ba_i))
              && (wr_data_o == $past(dq_i)) && (wr_en_o == !$past(dqm_i)));

  // R7
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_i |=> !wr_en_o);

  // R5
  page_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_act && !is_wr && full_sel) |=> (wr_col_o == $past(wr_col_o) + COL_W'(1)));

  // R8
  pre_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |-> !burst_act);

endmodule

// File: tb/tb_sdr_wr_engine.sv
module tb_sdr_wr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [15:0] dq = '0;
  logic        dqm = 1'b0;
  logic [2:0]  blen = 3'd0;
  logic        wr_en, pre;
  logic [1:0]  wr_bank, pre_bank;
  logic [7:0]  wr_col;
  logic [15:0] wr_data;

  always #10 clk = ~clk;

  sdr_wr_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .ba_i(ba), .addr_i(addr), .dq_i(dq), .dqm_i(dqm), .blen_i(blen),
    .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_col_o(wr_col), .wr_data_o(wr_data),
    .pre_o(pre), .pre_bank_o(pre_bank)
  );

  localparam logic [3:0] WR = 4'b0100, NOP = 4'b0111, RD = 4'b0101;

  typedef struct {
    bit         wen;
    bit         chk_loc;
    logic [1:0] bank;
    logic [7:0] col;
    logic [15:0] data;
    bit         pre;
    logic [1:0] pbank;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;

  bit         m_act = 0, m_full = 0, m_ap = 0;
  int         m_len = 1, m_cnt = 0;
  logic [7:0] m_col = '0;
  logic [1:0] m_bank = '0;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] cmd, input logic [1:0] b, input logic [11:0] a,
                     input logic [15:0] d, input bit mk, input string tag);
    exp_t e;
    bit last;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = cmd;
    ba = b; addr = a; dq = d; dqm = mk;
    e.wen = 0; e.chk_loc = 0; e.bank = '0; e.col = '0; e.data = '0;
    e.pre = 0; e.pbank = '0; e.tag = tag;
    if (cmd == WR) begin
      m_len = len_of(blen); m_full = (blen == 3'd7);
      m_col = a[7:0]; m_cnt = 1; m_bank = b; m_ap = a[10];
      e.chk_loc = 1; e.wen = !mk; e.bank = b; e.col = a[7:0]; e.data = d;
      last = !m_full && (m_len == 1);
      e.pre = last && m_ap; e.pbank = b;
      m_act = !last;
    end else if (m_act) begin
      if (m_full) m_col = m_col + 8'd1;
      else m_col = 8'(((int'(m_col) + 1) % m_len) + (int'(m_col) / m_len) * m_len);
      m_cnt++;
      e.chk_loc = 1; e.wen = !mk; e.bank = m_bank; e.col = m_col; e.data = d;
      last = !m_full && (m_cnt == m_len);
      e.pre = last && m_ap; e.pbank = m_bank;
      if (last) m_act = 0;
    end
    q.push_back(e);
  endtask

  // monitor: one expected item per edge after reset
  always @(posedge clk) begin : mon
    exp_t e;
    #5;
    if (rst_n && q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "wr_en", 32'(wr_en), 32'(e.wen));
      if (e.chk_loc) begin
        chk(e.tag, "bank", 32'(wr_bank), 32'(e.bank));
        chk(e.tag, "col", 32'(wr_col), 32'(e.col));
      end
      if (e.wen) chk(e.tag, "data", 32'(wr_data), 32'(e.data));
      chk(e.tag, "pre", 32'(pre), 32'(e.pre));
      if (e.pre) chk(e.tag, "pre_bank", 32'(pre_bank), 32'(e.pbank));
    end
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R10
    chk("R10", "wr_en", 32'(wr_en), 0);
    chk("R10", "pre", 32'(pre), 0);
    chk("R10", "col", 32'(wr_col), 0);
    chk("R10", "data", 32'(wr_data), 0);
    @(negedge clk); rst_n = 1'b1;

    cyc(NOP, 0, 12'h000, 16'h1111, 0, "R4");
    // length 2, start odd column wraps inside pair
    blen = 3'd1;
    cyc(WR, 1, 12'h005, 16'ha001, 0, "R2");
    cyc(NOP, 0, 12'h000, 16'ha002, 0, "R3");
    cyc(NOP, 0, 12'h000, 16'hbeef, 0, "R4");
    cyc(NOP, 0, 12'h000, 16'hcafe, 0, "R4");

    // length 8 with auto precharge, start 0x0d
    blen = 3'd3;
    cyc(WR, 2, 12'h40d, 16'hb000, 0, "R8");
    for (int i = 1; i < 8; i++) cyc(NOP, 0, 12'h000, 16'hb000 + 16'(i), 0, "R3");
    cyc(NOP, 0, 12'h000, 16'hdead, 0, "R4");
    cyc(NOP, 0, 12'h000, 16'hdead, 0, "R4");

    // length 1, back-to-back writes to different banks
    blen = 3'd0;
    cyc(WR, 0, 12'h410, 16'hc001, 0, "R6");
    cyc(WR, 3, 12'h420, 16'hc002, 0, "R6");
    cyc(WR, 3, 12'h021, 16'hc003, 0, "R6");
    cyc(NOP, 0, 12'h000, 16'h5555, 0, "R4");

    // length 4 with masked words
    blen = 3'd2;
    cyc(WR, 1, 12'h006, 16'hd000, 0, "R7");
    cyc(NOP, 0, 12'h000, 16'hd001, 1, "R7");
    cyc(NOP, 0, 12'h000, 16'hd002, 0, "R7");
    cyc(NOP, 0, 12'h000, 16'hd003, 1, "R7");
    cyc(NOP, 0, 12'h000, 16'hd004, 0, "R4");

    // truncation of an auto precharge burst
    blen = 3'd3;
    cyc(WR, 1, 12'h410, 16'he000, 0, "R9");
    cyc(NOP, 0, 12'h000, 16'he001, 0, "R6");
    cyc(NOP, 0, 12'h000, 16'he002, 0, "R6");
    cyc(WR, 2, 12'h033, 16'he100, 0, "R9");
    for (int i = 1; i < 8; i++) cyc(NOP, 0, 12'h000, 16'he100 + 16'(i), 0, "R9");
    cyc(NOP, 0, 12'h000, 16'h7777, 0, "R4");

    // non-write commands ignored
    cyc(RD, 1, 12'h412, 16'h0f0f, 0, "R1");
    cyc(4'b1100, 2, 12'h413, 16'h0f1f, 0, "R1");
    cyc(4'b0000, 3, 12'h414, 16'h0f2f, 0, "R1");
    cyc(4'b0110, 0, 12'h415, 16'h0f3f, 0, "R1");

    // reserved code acts as length 1
    blen = 3'd5;
    cyc(WR, 2, 12'h444, 16'hf000, 0, "R3");
    cyc(NOP, 0, 12'h000, 16'hf001, 0, "R4");

    // full page wraps 255 -> 0, then truncation cancels its precharge
    blen = 3'd7;
    cyc(WR, 0, 12'h4fd, 16'h9000, 0, "R5");
    for (int i = 1; i < 7; i++) cyc(NOP, 0, 12'h000, 16'h9000 + 16'(i), 0, "R5");
    cyc(WR, 1, 12'h080, 16'h9100, 0, "R9");
    for (int i = 1; i < 4; i++) cyc(NOP, 0, 12'h000, 16'h9100 + 16'(i), 0, "R5");

    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = NOP;
    while (q.size() > 0) @(posedge clk);
    @(posedge clk); #6;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule